// File: doc/BRIEF.md
# Hot-Swap Startup and Fault Controller

This block is the digital sequencer of a hot-swap power controller for a board plugged into a live backplane. It receives already-digitised comparator decisions: an under-voltage-good level, an over-voltage level, an inrush-limiting indication, an over-current indication and a ramp-complete indication. From these it decides when the external pass transistor may be driven, when the ramp capacitor must be emptied, when startup has finished and when the power-good flag chain must be cleared.

After the input voltage enters its allowed window, a counted debounce delay runs before the gate is enabled. Inrush then runs under a counted startup timeout. Completion arms the over-current breaker and emits a one-cycle strobe to the flag sequencer. A timeout or a breaker trip turns the gate off and records the cause. The controller then either waits through a long counted cool-down, built as a divided oscillator counted over a number of full periods, and restarts, or it stays off until the window is lost and regained, as chosen by a strap. All delays advance only on a clock-enable tick, so their tick counts are parameters.

Top module: `hotswap_ctrl`

## Requirements
- R1: Whenever `uv_ok` is low or `ov_fault` is high, `gate_en` is low, `ramp_dump` is high and `flag_clr` is high in that same cycle, in every state. Once the window is valid again, a new start begins.
- R2: While `supply_ok` is low, `gate_en` is low, `ramp_dump` and `flag_clr` are high, and on the next clock `fault_cause` is 00 and `start_done` and `cb_armed` are low.
- R3: Once the window is valid, the controller counts DEB_TICKS ticks in a debounce phase that starts on the next clock. `gate_en` rises on the clock after the count is reached. A window drop during debounce restarts the count from zero.
- R4: While ramping, `ramp_done` high together with `ilim_active` low ends startup on the next clock: `start_done` is high for exactly one cycle, `cb_armed` rises and `flag_clr` falls. `ramp_done` while `ilim_active` is high does not end startup.
- R5: If startup does not end within TMO_TICKS ticks of the gate being enabled, `gate_en` falls on the following clock and `fault_cause` becomes 01.
- R6: `cb_over` has no effect before startup ends. After startup ends, `cb_over` high drops `gate_en` in the same cycle, drops `cb_armed` on the next clock and sets `fault_cause` to 10.
- R7: With `retry_dis` low, a fault starts a cool-down of 2*OSC_HALF_TICKS*RETRY_CYCLES ticks. On the next clock a new debounce begins and `fault_cause` returns to 00. `fault_cause` is never nonzero while `gate_en` is high.
- R8: With `retry_dis` high, a fault keeps the gate off and the cause held for any length of time, until the window is lost. The next valid window starts a new debounce.
- R9: Debounce, timeout and cool-down counts advance only in cycles where `tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Clock enable for all delay counts |
| supply_ok | input | 1 | Internal supply lockout satisfied |
| uv_ok | input | 1 | Input above under-voltage threshold (hysteresis applied) |
| ov_fault | input | 1 | Input above over-voltage threshold (hysteresis applied) |
| ilim_active | input | 1 | Inrush current limiting in progress |
| cb_over | input | 1 | Over-current breaker threshold exceeded |
| ramp_done | input | 1 | Ramp voltage has reached its completion level |
| retry_dis | input | 1 | Strap: 1 selects latched-off behaviour after a fault |
| gate_en | output | 1 | Enable for the pass transistor gate drive |
| ramp_dump | output | 1 | Request to discharge the ramp capacitor |
| start_done | output | 1 | One-cycle strobe when startup completes |
| flag_clr | output | 1 | Clears the power-good flag sequencer |
| cb_armed | output | 1 | Over-current breaker is armed |
| fault_cause | output | 2 | 00 none, 01 startup timeout, 10 breaker trip |

## Verification
On every cycle the assertions check several rules. The gate is off and the ramp is dumped whenever the voltage window is bad. Lockout clears the cause and the strobe. An armed breaker with over-current forces the gate off in the same cycle. The breaker arms only together with the completion strobe, which lasts one cycle. A recorded cause never coexists with an enabled gate. The exact lengths of the debounce, timeout and cool-down delays can only be shown by the bench scenarios, which count cycles. The same holds for the restart of debounce after a window glitch, for tick gating, for ilim blocking completion and for the latched-off hold until the window is cycled.

// File: rtl/hs_pkg.sv
package hs_pkg;
   typedef enum logic [2:0] {
      ST_OFF,
      ST_DEB,
      ST_RAMP,
      ST_RUN,
      ST_COOL,
      ST_HOLD
   } hs_state_t;

   typedef enum logic [1:0] {
      CAUSE_NONE = 2'b00,
      CAUSE_TMO  = 2'b01,
      CAUSE_CB   = 2'b10
   } hs_cause_t;
endpackage

// File: rtl/hs_timer.sv
module hs_timer #(
   parameter int LIMIT = 2000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   output logic done
);
   localparam int W = $clog2(LIMIT + 1);
   localparam logic [W-1:0] LIM_V = W'(LIMIT);

   generate
      if (LIMIT < 1) begin : g_bad
         $error("hs_timer: LIMIT must be at least 1");
      end
   endgenerate

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (clr)               cnt_q <= '0;
      else if (tick && !done)     cnt_q <= cnt_q + 1'b1;
   end

   assign done = (cnt_q == LIM_V);
endmodule

// File: rtl/hs_cooldown.sv
module hs_cooldown #(
   parameter int HALF_TICKS = 31250,
   parameter int CYCLES     = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   output logic done
);
   localparam int CW = $clog2(CYCLES + 1);
   localparam logic [CW-1:0] CYC_V = CW'(CYCLES);

   generate
      if (HALF_TICKS < 1 || CYCLES < 1) begin : g_bad
         $error("hs_cooldown: HALF_TICKS and CYCLES must be at least 1");
      end
   endgenerate

   logic half_wrap;

   generate
      if (HALF_TICKS == 1) begin : g_direct
         assign half_wrap = tick & ~clr & ~done;
      end else begin : g_div
         localparam int HW = $clog2(HALF_TICKS);
         localparam logic [HW-1:0] HTOP = HW'(HALF_TICKS - 1);
         logic [HW-1:0] hc_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  hc_q <= '0;
            else if (clr)                hc_q <= '0;
            else if (tick && !done) begin
               if (hc_q == HTOP)         hc_q <= '0;
               else                      hc_q <= hc_q + 1'b1;
            end
         end
         assign half_wrap = tick & ~clr & ~done & (hc_q == HTOP);
      end
   endgenerate

   logic          phase_q;
   logic [CW-1:0] cyc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= 1'b0;
         cyc_q   <= '0;
      end else if (clr) begin
         phase_q <= 1'b0;
         cyc_q   <= '0;
      end else if (half_wrap) begin
         phase_q <= ~phase_q;
         if (phase_q) cyc_q <= cyc_q + 1'b1;
      end
   end

   assign done = (cyc_q == CYC_V);
endmodule

// File: rtl/hotswap_ctrl.sv
module hotswap_ctrl #(
   parameter int DEB_TICKS      = 2000,
   parameter int TMO_TICKS      = 100000,
   parameter int OSC_HALF_TICKS = 31250,
   parameter int RETRY_CYCLES   = 256
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       supply_ok,
   input  logic       uv_ok,
   input  logic       ov_fault,
   input  logic       ilim_active,
   input  logic       cb_over,
   input  logic       ramp_done,
   input  logic       retry_dis,
   output logic       gate_en,
   output logic       ramp_dump,
   output logic       start_done,
   output logic       flag_clr,
   output logic       cb_armed,
   output logic [1:0] fault_cause
);
   import hs_pkg::*;

   hs_state_t state_q, state_d;
   hs_cause_t cause_q;
   logic      start_q;
   logic      win_ok, live, deb_done, tmo_done, cool_done;
   logic      in_run, trip, fault_state_is_cool;

   assign win_ok = uv_ok & ~ov_fault;
   assign live   = win_ok & supply_ok;
   assign in_run = (state_q == ST_RUN);
   assign trip   = in_run & cb_over;
   assign fault_state_is_cool = ~retry_dis;

   hs_timer #(.LIMIT(DEB_TICKS)) u_deb (
      .clk(clk), .rst_n(rst_n), .clr(state_q != ST_DEB), .tick(tick), .done(deb_done)
   );

   hs_timer #(.LIMIT(TMO_TICKS)) u_tmo (
      .clk(clk), .rst_n(rst_n), .clr(state_q != ST_RAMP), .tick(tick), .done(tmo_done)
   );

   hs_cooldown #(.HALF_TICKS(OSC_HALF_TICKS), .CYCLES(RETRY_CYCLES)) u_cool (
      .clk(clk), .rst_n(rst_n), .clr(state_q != ST_COOL), .tick(tick), .done(cool_done)
   );

   always_comb begin
      state_d = state_q;
      if (!live) begin
         state_d = ST_OFF;
      end else begin
         case (state_q)
            ST_OFF:  state_d = ST_DEB;
            ST_DEB:  if (deb_done) state_d = ST_RAMP;
            ST_RAMP: begin
               if (ramp_done && !ilim_active) state_d = ST_RUN;
               else if (tmo_done) state_d = fault_state_is_cool ? ST_COOL : ST_HOLD;
            end
            ST_RUN:  if (cb_over) state_d = fault_state_is_cool ? ST_COOL : ST_HOLD;
            ST_COOL: if (cool_done) state_d = ST_DEB;
            ST_HOLD: state_d = ST_HOLD;
            default: state_d = ST_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_OFF;
         cause_q <= CAUSE_NONE;
         start_q <= 1'b0;
      end else if (!supply_ok) begin
         state_q <= ST_OFF;
         cause_q <= CAUSE_NONE;
         start_q <= 1'b0;
      end else begin
         state_q <= state_d;
         start_q <= (state_d == ST_RUN) && (state_q == ST_RAMP);
         if (state_d == ST_DEB && state_q != ST_DEB)
            cause_q <= CAUSE_NONE;
         else if (state_q == ST_RAMP && (state_d == ST_COOL || state_d == ST_HOLD))
            cause_q <= CAUSE_TMO;
         else if (state_q == ST_RUN && (state_d == ST_COOL || state_d == ST_HOLD))
            cause_q <= CAUSE_CB;
      end
   end

   assign gate_en     = ((state_q == ST_RAMP) || in_run) & live & ~trip;
   assign ramp_dump   = ~((state_q == ST_DEB) || (state_q == ST_RAMP) || in_run) | ~live;
   assign flag_clr    = ~(in_run & gate_en);
   assign cb_armed    = in_run;
   assign start_done  = start_q;
   assign fault_cause = cause_q;
endmodule

// File: rtl/hs_checker.sv
module hs_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       supply_ok,
   input logic       uv_ok,
   input logic       ov_fault,
   input logic       cb_over,
   input logic       gate_en,
   input logic       ramp_dump,
   input logic       start_done,
   input logic       flag_clr,
   input logic       cb_armed,
   input logic [1:0] fault_cause
);
   assert_window_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!uv_ok || ov_fault) |-> (!gate_en && ramp_dump && flag_clr));

   assert_lockout_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |=> (fault_cause == 2'b00 && !start_done && !cb_armed));

   assert_lockout_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |-> (!gate_en && ramp_dump));

   assert_arm_with_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cb_armed) |-> start_done);

   assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      start_done |=> !start_done);

   assert_breaker_cut_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cb_armed && cb_over) |-> !gate_en);

   assert_cause_gate_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_cause != 2'b00) |-> !gate_en);

   assert_cause_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fault_cause));
endmodule

bind hotswap_ctrl hs_checker u_hs_checker (.*);

// File: tb/tb_hotswap_ctrl.sv
module tb_hotswap_ctrl;
   localparam int DEB  = 4;
   localparam int TMO  = 20;
   localparam int HALF = 2;
   localparam int CYC  = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b1, supply_ok = 1'b1, uv_ok = 1'b0, ov_fault = 1'b0;
   logic ilim_active = 1'b0, cb_over = 1'b0, ramp_done = 1'b0, retry_dis = 1'b0;
   logic gate_en, ramp_dump, start_done, flag_clr, cb_armed;
   logic [1:0] fault_cause;

   int tests = 0, fails = 0;
   bit done_flag = 1'b0;

   always #4 clk = ~clk;

   hotswap_ctrl #(.DEB_TICKS(DEB), .TMO_TICKS(TMO), .OSC_HALF_TICKS(HALF), .RETRY_CYCLES(CYC)) dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok), .uv_ok(uv_ok),
      .ov_fault(ov_fault), .ilim_active(ilim_active), .cb_over(cb_over),
      .ramp_done(ramp_done), .retry_dis(retry_dis), .gate_en(gate_en),
      .ramp_dump(ramp_dump), .start_done(start_done), .flag_clr(flag_clr),
      .cb_armed(cb_armed), .fault_cause(fault_cause)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic go_idle();
      uv_ok = 1'b0; ov_fault = 1'b0; cb_over = 1'b0; ramp_done = 1'b0;
      ilim_active = 1'b0; retry_dis = 1'b0; tick = 1'b1; supply_ok = 1'b1;
      cyc(2);
   endtask

   task automatic bring_up();
      uv_ok = 1'b1;
      cyc(DEB + 2);
   endtask

   task automatic finish_start();
      ramp_done = 1'b1; ilim_active = 1'b0;
      cyc(1);
      ramp_done = 1'b0;
   endtask

   task automatic t_reset();
      #1;
      chk(gate_en, 0, "R2 reset gate");
      chk(ramp_dump, 1, "R2 reset ramp_dump");
      chk(flag_clr, 1, "R2 reset flag_clr");
      chk(fault_cause, 0, "R2 reset cause");
      chk(cb_armed, 0, "R2 reset cb_armed");
      chk(start_done, 0, "R2 reset strobe");
   endtask

   task automatic t_debounce();
      uv_ok = 1'b1;
      cyc(DEB + 1);
      chk(gate_en, 0, "R3 gate still off at end of debounce");
      cyc(1);
      chk(gate_en, 1, "R3 gate on after debounce");
      go_idle();
      uv_ok = 1'b1;
      cyc(DEB);
      uv_ok = 1'b0;
      cyc(1);
      uv_ok = 1'b1;
      cyc(DEB + 1);
      chk(gate_en, 0, "R3 debounce restarted after glitch");
      cyc(1);
      chk(gate_en, 1, "R3 gate on after full restarted debounce");
      go_idle();
   endtask

   task automatic t_tick();
      tick = 1'b0;
      uv_ok = 1'b1;
      cyc(30);
      chk(gate_en, 0, "R9 no progress without tick");
      tick = 1'b1;
      cyc(DEB);
      chk(gate_en, 0, "R9 gate off before counted ticks");
      cyc(1);
      chk(gate_en, 1, "R9 gate on after DEB ticks");
      go_idle();
   endtask

   task automatic t_complete();
      bring_up();
      ramp_done = 1'b1; ilim_active = 1'b1;
      cyc(2);
      chk(start_done, 0, "R4 no completion while limiting");
      chk(cb_armed, 0, "R4 breaker not armed while limiting");
      ilim_active = 1'b0;
      cyc(1);
      chk(start_done, 1, "R4 completion strobe");
      chk(cb_armed, 1, "R4 breaker armed");
      chk(flag_clr, 0, "R4 flag clear released");
      ramp_done = 1'b0;
      cyc(1);
      chk(start_done, 0, "R4 strobe lasts one cycle");
      go_idle();
   endtask

   task automatic t_timeout_retry();
      bring_up();
      cyc(TMO);
      chk(gate_en, 1, "R5 gate on until timeout");
      cyc(1);
      chk(gate_en, 0, "R5 gate off at timeout");
      chk(fault_cause, 1, "R5 cause timeout");
      cyc(2 * HALF * CYC);
      chk(fault_cause, 1, "R7 cause held through cool-down");
      chk(gate_en, 0, "R7 gate off through cool-down");
      cyc(1);
      chk(fault_cause, 0, "R7 cause cleared on restart");
      cyc(DEB);
      chk(gate_en, 0, "R7 restart debounce running");
      cyc(1);
      chk(gate_en, 1, "R7 gate on after retry");
      go_idle();
   endtask

   task automatic t_breaker();
      bring_up();
      cb_over = 1'b1;
      cyc(3);
      chk(gate_en, 1, "R6 breaker ignored during ramp");
      chk(fault_cause, 0, "R6 no cause during ramp");
      cb_over = 1'b0;
      finish_start();
      chk(cb_armed, 1, "R6 armed after start");
      cb_over = 1'b1;
      #1;
      chk(gate_en, 0, "R6 gate off same cycle on trip");
      cyc(1);
      chk(cb_armed, 0, "R6 disarmed after trip");
      chk(fault_cause, 2, "R6 cause breaker");
      cb_over = 1'b0;
      go_idle();
   endtask

   task automatic t_latched();
      retry_dis = 1'b1;
      bring_up();
      cyc(TMO + 1);
      chk(fault_cause, 1, "R8 timeout cause latched");
      cyc(100);
      chk(gate_en, 0, "R8 stays off beyond cool-down time");
      chk(fault_cause, 1, "R8 cause still held");
      uv_ok = 1'b0;
      cyc(1);
      uv_ok = 1'b1;
      cyc(1);
      chk(fault_cause, 0, "R8 cause cleared on new start");
      cyc(DEB + 1);
      chk(gate_en, 1, "R8 gate on after window cycled");
      ov_fault = 1'b1;
      cyc(1);
      ov_fault = 1'b0;
      retry_dis = 1'b1;
      cyc(DEB + 2 + TMO + 1);
      chk(fault_cause, 1, "R2 cause set before lockout");
      supply_ok = 1'b0;
      #1;
      chk(ramp_dump, 1, "R2 ramp dumped in lockout");
      cyc(1);
      chk(fault_cause, 0, "R2 lockout clears cause");
      cyc(5);
      chk(gate_en, 0, "R2 gate held off in lockout");
      go_idle();
   endtask

   task automatic t_window_loss();
      bring_up();
      finish_start();
      ov_fault = 1'b1;
      #1;
      chk(gate_en, 0, "R1 gate off on over-voltage");
      chk(ramp_dump, 1, "R1 ramp dumped");
      chk(flag_clr, 1, "R1 flags cleared");
      cyc(1);
      chk(cb_armed, 0, "R1 breaker disarmed");
      ov_fault = 1'b0;
      cyc(DEB + 2);
      chk(gate_en, 1, "R1 new start after window returns");
      go_idle();
   endtask

   initial begin
      cyc(2);
      t_reset();
      rst_n = 1'b1;
      cyc(2);
      t_reset();
      t_debounce();
      t_tick();
      t_complete();
      t_timeout_retry();
      t_breaker();
      t_latched();
      t_window_loss();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done_flag) begin
         done_flag = 1'b1;
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule